// File: doc/BRIEF.md
# Super-block Reuse-Filtering Allocation Controller

This block manages one set of a set-associative last-level cache in which each way carries a super-block tag instead of a block tag. A super-block covers four aligned, contiguous blocks, and all four map to the same set. Each tag holds a presence state for each of its four blocks: invalid, valid, or first-use. The block handles uncompressed blocks only. Data storage, replacement priority, coherence and DRAM timing are outside it.

On every request, read or writeback, the controller compares the super-block tag with the set. It then decides whether to allocate a data entry, to serve the request without allocating, or to forward a writeback to DRAM. If the super-block tag is already present but the requested block is absent, the block is not placed on that first touch. The controller only records a first-use mark in the tag. A data entry is spent on that block only when it is touched a second time, so blocks that are used once do not displace blocks that are reused.

The controller accepts one request per cycle and reports the outcome on registered outputs one cycle later. An external replacement policy supplies the way to evict when no way is free.

Top module: `sbc_alloc_ctrl`

## Requirements
- R1: The request address is split from the least significant bit upward: a 6-bit byte offset (bits 5:0), a 2-bit block ID (bits 7:6), a 4-bit set index (bits 11:8), and the super-block tag (bits 31:12). The offset and index bits do not affect the outcome.
- R2: After reset every way is empty, so the first read of any address is a miss that allocates.
- R3: A read whose super-block tag matches no way allocates a way. The response has `rsp_alloc`=1, `rsp_hit`=0, and `rsp_way` set to the lowest-numbered empty way. In the new tag the requested block is valid and the other three blocks are invalid.
- R4: A read that matches a tag in which the requested block is invalid, with no matching tag holding it valid or first-use, gives `rsp_bypass`=1 and no allocation. The block becomes first-use in that tag.
- R5: A read of a block that is first-use in a matching tag allocates a new way with a fresh tag for the same super-block, and the block is valid there. The block becomes invalid in every earlier matching tag. A later read of the block hits the new way.
- R6: When several tags in the set match and none holds the requested block, the block becomes first-use in every matching tag. A second read then allocates exactly once.
- R7: A read of a block that is valid in a matching tag gives `rsp_hit`=1, with `rsp_way` naming that way, and changes no state.
- R8: A writeback to a block that is valid in a matching tag gives `rsp_hit`=1, with `rsp_way` naming that way, `rsp_dram_fwd`=0 and `rsp_alloc`=0.
- R9: A writeback that matches no tag, or that finds the block only as first-use, gives `rsp_dram_fwd`=1 and changes no state. A following read behaves exactly as it would have without the writeback.
- R10: No two tags in the set ever hold the same block as valid.
- R11: When all four ways are occupied, an allocation uses the way given on `victim_way` and reports `rsp_evict`=1. An allocation into an empty way reports `rsp_evict`=0.
- R12: The response is registered. `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid`=1, and 0 otherwise. `rsp_way` is 0 when neither `rsp_hit` nor `rsp_alloc` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_wb | input | 1 | 1 = writeback, 0 = read |
| req_addr | input | 32 | Byte address; the block ID is taken from bits 7:6 |
| victim_way | input | 2 | Way to evict when the set is full |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | The block was valid in the set |
| rsp_bypass | output | 1 | Read served without allocating (first touch) |
| rsp_dram_fwd | output | 1 | Writeback sent straight to DRAM |
| rsp_alloc | output | 1 | A data entry was allocated |
| rsp_evict | output | 1 | The allocated way held a live tag |
| rsp_way | output | 2 | Way that hit or was allocated |

## Verification
The bench walks one super-block through the full state sequence for each block:
- a global miss;
- a repeat hit;
- a first touch, which bypasses;
- a writeback to the first-use block, which must not promote it;
- the second touch, which allocates.

A block read while two tags of its super-block are live shows whether the first-use mark is applied to every matching tag, and the reuse that follows shows whether it is cleared in all of them. A writeback to an absent super-block, followed by a read of it, separates "forward and leave state alone" from "forward and allocate". Once the set is full, the bench chooses different victims to show that the external choice is obeyed, that eviction is flagged, and that an evicted block reverts to first-touch behaviour.

// File: rtl/sbc_pkg.sv
// Shared types for the super-block allocation controller.
// Assumes four blocks per super-block; per-block presence is a 2-bit code.
package sbc_pkg;
    localparam int SB_BLOCKS = 4;
    localparam int BLK_W     = $clog2(SB_BLOCKS);

    typedef enum logic [1:0] {
        BS_INV = 2'd0,
        BS_VAL = 2'd1,
        BS_FU  = 2'd2
    } blk_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
// Tag, valid flag and per-block presence storage for one set.
// Applies a masked per-block state update, then an optional install that
// overwrites one way with a fresh tag (install wins on the same way).
module sbc_tag_store
    import sbc_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_WAYS-1:0]                       upd_mask,
    input  logic [BLK_W-1:0]                          upd_blk,
    input  logic [1:0]                                upd_state,
    input  logic                                      ins_en,
    input  logic [WAY_W-1:0]                          ins_way,
    input  logic [TAG_W-1:0]                          ins_tag,
    input  logic [BLK_W-1:0]                          ins_blk,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]            tag_q,
    output logic [NUM_WAYS-1:0]                       valid_q,
    output logic [NUM_WAYS-1:0][SB_BLOCKS-1:0][1:0]   state_q
);

    // Purpose: hold the set contents and apply update and install commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= '0;
            state_q <= '0;
        end else begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (upd_mask[w]) begin
                    state_q[w][upd_blk] <= upd_state;
                end
                if (ins_en && ins_way == WAY_W'(w)) begin
                    valid_q[w] <= 1'b1;
                    tag_q[w]   <= ins_tag;
                    for (int b = 0; b < SB_BLOCKS; b++) begin
                        state_q[w][b] <= (ins_blk == BLK_W'(b)) ? BS_VAL : BS_INV;
                    end
                end
            end
        end
    end

    // R4: a way that takes a state update must already hold a live tag.
    a_r4_update_live_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_mask) |-> ((upd_mask & ~valid_q) == '0));

endmodule

// File: rtl/sbc_tag_match.sv
// Compares the requested super-block tag against every way of the set and
// reports, per way, a tag match and whether the requested block is valid
// or first-use there. Pure combinational.
module sbc_tag_match
    import sbc_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20
) (
    input  logic [TAG_W-1:0]                          req_tag,
    input  logic [BLK_W-1:0]                          req_blk,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]            tag_q,
    input  logic [NUM_WAYS-1:0]                       valid_q,
    input  logic [NUM_WAYS-1:0][SB_BLOCKS-1:0][1:0]   state_q,
    output logic [NUM_WAYS-1:0]                       match,
    output logic [NUM_WAYS-1:0]                       val_hit,
    output logic [NUM_WAYS-1:0]                       fu_hit
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        // Purpose: per-way tag compare and presence lookup of the requested block.
        always_comb begin
            match[w]   = valid_q[w] && (tag_q[w] == req_tag);
            val_hit[w] = match[w] && (state_q[w][req_blk] == BS_VAL);
            fu_hit[w]  = match[w] && (state_q[w][req_blk] == BS_FU);
        end
    end

endmodule

// File: rtl/sbc_way_pick.sv
// Chooses the way for an allocation: the lowest-numbered empty way, or the
// externally supplied victim when every way is occupied.
module sbc_way_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAYS-1:0] valid_q,
    input  logic [WAY_W-1:0]    victim_way,
    output logic [WAY_W-1:0]    pick_way,
    output logic                pick_evict
);

    logic [NUM_WAYS-1:0] empty;

    // Purpose: priority search for an empty way with victim fallback.
    always_comb begin
        empty      = ~valid_q;
        pick_way   = victim_way;
        pick_evict = 1'b1;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (empty[w]) begin
                pick_way   = WAY_W'(w);
                pick_evict = 1'b0;
            end
        end
    end

    // R11: while any way is empty, the chosen way is one of the empty ones.
    a_r11_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q != '1) |-> !valid_q[pick_way]);

    // R11: eviction is reported only when the set is full.
    a_r11_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        pick_evict |-> (valid_q == '1));

endmodule

// File: rtl/sbc_alloc_ctrl.sv
// Allocation controller for one set of a super-block-tagged cache.
// Decides allocate / first-use bypass / DRAM forward per request and
// registers the outcome. Assumes the caller routes only requests for this
// set; the index and offset bits are ignored. One request per cycle.
module sbc_alloc_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 6,
    parameter int IDX_W    = 4,
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int BLK_LSB = OFF_W,
    localparam int TAG_LSB = OFF_W + BLK_W + IDX_W,
    localparam int TAG_W   = ADDR_W - TAG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wb,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_bypass,
    output logic              rsp_dram_fwd,
    output logic              rsp_alloc,
    output logic              rsp_evict,
    output logic [WAY_W-1:0]  rsp_way
);

    logic [TAG_W-1:0] req_tag;
    logic [BLK_W-1:0] req_blk;
    logic             unused_addr_bits;

    assign req_tag          = req_addr[ADDR_W-1:TAG_LSB];
    assign req_blk          = req_addr[BLK_LSB +: BLK_W];
    assign unused_addr_bits = ^{req_addr[TAG_LSB-1:BLK_LSB+BLK_W], req_addr[OFF_W-1:0]};

    logic [NUM_WAYS-1:0][TAG_W-1:0]          tag_q;
    logic [NUM_WAYS-1:0]                     valid_q;
    logic [NUM_WAYS-1:0][SB_BLOCKS-1:0][1:0] state_q;
    logic [NUM_WAYS-1:0]                     match, val_hit, fu_hit;
    logic [WAY_W-1:0]                        pick_way;
    logic                                    pick_evict;

    logic [NUM_WAYS-1:0] upd_mask;
    logic [1:0]          upd_state;
    logic                ins_en;
    logic [WAY_W-1:0]    val_way;
    logic                n_hit, n_bypass, n_fwd, n_alloc, n_evict;
    logic [WAY_W-1:0]    n_way;

    sbc_tag_store #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_mask  (upd_mask),
        .upd_blk   (req_blk),
        .upd_state (upd_state),
        .ins_en    (ins_en),
        .ins_way   (pick_way),
        .ins_tag   (req_tag),
        .ins_blk   (req_blk),
        .tag_q     (tag_q),
        .valid_q   (valid_q),
        .state_q   (state_q)
    );

    sbc_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
        .req_tag (req_tag),
        .req_blk (req_blk),
        .tag_q   (tag_q),
        .valid_q (valid_q),
        .state_q (state_q),
        .match   (match),
        .val_hit (val_hit),
        .fu_hit  (fu_hit)
    );

    sbc_way_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_q    (valid_q),
        .victim_way (victim_way),
        .pick_way   (pick_way),
        .pick_evict (pick_evict)
    );

    // Purpose: locate the way that holds the requested block as valid.
    always_comb begin
        val_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (val_hit[w]) val_way = WAY_W'(w);
        end
    end

    // Purpose: choose the action for the current request and its state edits.
    always_comb begin
        upd_mask  = '0;
        upd_state = BS_INV;
        ins_en    = 1'b0;
        n_hit     = 1'b0;
        n_bypass  = 1'b0;
        n_fwd     = 1'b0;
        n_alloc   = 1'b0;
        n_evict   = 1'b0;
        n_way     = '0;
        if (req_valid) begin
            if (|val_hit) begin
                n_hit = 1'b1;
                n_way = val_way;
            end else if (req_wb) begin
                n_fwd = 1'b1;
            end else if (!(|match)) begin
                ins_en  = 1'b1;
                n_alloc = 1'b1;
                n_evict = pick_evict;
                n_way   = pick_way;
            end else if (|fu_hit) begin
                ins_en    = 1'b1;
                upd_mask  = match;
                upd_state = BS_INV;
                n_alloc   = 1'b1;
                n_evict   = pick_evict;
                n_way     = pick_way;
            end else begin
                upd_mask  = match;
                upd_state = BS_FU;
                n_bypass  = 1'b1;
            end
        end
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_bypass   <= 1'b0;
            rsp_dram_fwd <= 1'b0;
            rsp_alloc    <= 1'b0;
            rsp_evict    <= 1'b0;
            rsp_way      <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_hit      <= n_hit;
            rsp_bypass   <= n_bypass;
            rsp_dram_fwd <= n_fwd;
            rsp_alloc    <= n_alloc;
            rsp_evict    <= n_evict;
            rsp_way      <= n_way;
        end
    end

    // R10: a block is never valid in two tags at once.
    a_r10_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(val_hit));

    // R4: a bypassed read neither hits nor allocates.
    a_r4_bypass_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_bypass) |-> (!rsp_alloc && !rsp_hit));

    // R9: a writeback never allocates nor bypasses.
    a_r9_wb_never_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wb) |=> (!rsp_alloc && !rsp_bypass));

    // R12: a response follows each request by exactly one cycle.
    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12: no response without a request in the previous cycle.
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

endmodule

// File: tb/sbc_alloc_ctrl_bench.sv
`timescale 1ns/1ps
module sbc_alloc_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wb = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  victim_way = '0;
    logic        rsp_valid, rsp_hit, rsp_bypass, rsp_dram_fwd, rsp_alloc, rsp_evict;
    logic [1:0]  rsp_way;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [19:0] SB_A = 20'h0A1B2;
    localparam logic [19:0] SB_B = 20'h0B3C4;
    localparam logic [19:0] SB_C = 20'h0C5D6;

    always #4 clk = ~clk;

    sbc_alloc_ctrl u_sbc_alloc_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_wb       (req_wb),
        .req_addr     (req_addr),
        .victim_way   (victim_way),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_bypass   (rsp_bypass),
        .rsp_dram_fwd (rsp_dram_fwd),
        .rsp_alloc    (rsp_alloc),
        .rsp_evict    (rsp_evict),
        .rsp_way      (rsp_way)
    );

    function automatic logic [31:0] mk(input logic [19:0] t, input logic [1:0] b,
                                       input logic [3:0] idx);
        return {t, idx, b, 6'h15};
    endfunction

    // Issue one request and leave the bench at the negedge where the response is visible.
    task automatic issue(input bit wb, input logic [31:0] a, input logic [1:0] vic);
        @(negedge clk);
        req_valid  = 1'b1;
        req_wb     = wb;
        req_addr   = a;
        victim_way = vic;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // Compare the response fields (the {valid,hit,bypass,fwd,alloc,evict} flags and the way when meaningful).
    task automatic expect_rsp(input string rq, input logic [5:0] flags,
                              input logic [1:0] way, input bit chk_way);
        logic [5:0] act;
        act = {rsp_valid, rsp_hit, rsp_bypass, rsp_dram_fwd, rsp_alloc, rsp_evict};
        n_tests++;
        if (act !== flags || (chk_way && rsp_way !== way)) begin
            n_fail++;
            $display("FAIL %s: flags=%b way=%0d expected flags=%b way=%0d",
                     rq, act, rsp_way, flags, way);
        end
    endtask

    // Flag encodings: {valid,hit,bypass,fwd,alloc,evict}.
    localparam logic [5:0] F_HIT   = 6'b110000;
    localparam logic [5:0] F_BYP   = 6'b101000;
    localparam logic [5:0] F_FWD   = 6'b100100;
    localparam logic [5:0] F_ALLOC = 6'b100010;
    localparam logic [5:0] F_EVICT = 6'b100011;

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_rsp("R12 idle after reset", 6'b000000, 2'd0, 1'b1);
    endtask

    task automatic t_global_miss;
        issue(1'b0, mk(SB_A, 2'd2, 4'h3), 2'd3);
        expect_rsp("R2 R3 first read allocates way0", F_ALLOC, 2'd0, 1'b1);
        @(negedge clk);
        expect_rsp("R12 no response without request", 6'b000000, 2'd0, 1'b1);
    endtask

    task automatic t_hit_and_split;
        issue(1'b0, mk(SB_A, 2'd2, 4'hA), 2'd3);
        expect_rsp("R1 R7 hit with different index bits", F_HIT, 2'd0, 1'b1);
    endtask

    task automatic t_first_touch;
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R4 first touch bypasses", F_BYP, 2'd0, 1'b1);
        issue(1'b1, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R9 writeback to first-use forwards", F_FWD, 2'd0, 1'b1);
    endtask

    task automatic t_reuse;
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R5 R9 second touch allocates way1", F_ALLOC, 2'd1, 1'b1);
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R5 reuse then hits way1", F_HIT, 2'd1, 1'b1);
    endtask

    task automatic t_multi_match;
        issue(1'b0, mk(SB_A, 2'd3, 4'h3), 2'd3);
        expect_rsp("R6 two matching tags bypass", F_BYP, 2'd0, 1'b1);
        issue(1'b0, mk(SB_A, 2'd3, 4'h3), 2'd3);
        expect_rsp("R6 reuse allocates way2 once", F_ALLOC, 2'd2, 1'b1);
        issue(1'b0, mk(SB_A, 2'd3, 4'h3), 2'd3);
        expect_rsp("R6 R10 block then hits way2", F_HIT, 2'd2, 1'b1);
    endtask

    task automatic t_writebacks;
        issue(1'b1, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R8 writeback to valid block", F_HIT, 2'd1, 1'b1);
        issue(1'b1, mk(SB_B, 2'd1, 4'h3), 2'd3);
        expect_rsp("R9 writeback full miss forwards", F_FWD, 2'd0, 1'b1);
        issue(1'b0, mk(SB_B, 2'd1, 4'h3), 2'd0);
        expect_rsp("R9 R3 read after forward is global miss", F_ALLOC, 2'd3, 1'b1);
    endtask

    task automatic t_full_set;
        issue(1'b0, mk(SB_C, 2'd0, 4'h3), 2'd1);
        expect_rsp("R11 full set evicts chosen way1", F_EVICT, 2'd1, 1'b1);
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd1);
        expect_rsp("R11 R6 evicted block is first touch again", F_BYP, 2'd0, 1'b1);
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd3);
        expect_rsp("R11 R5 reuse evicts chosen way3", F_EVICT, 2'd3, 1'b1);
        issue(1'b0, mk(SB_A, 2'd0, 4'h3), 2'd0);
        expect_rsp("R5 hit in way3", F_HIT, 2'd3, 1'b1);
        issue(1'b0, mk(SB_B, 2'd1, 4'h3), 2'd2);
        expect_rsp("R11 evicted super-block misses into way2", F_EVICT, 2'd2, 1'b1);
    endtask

    initial begin
        t_reset();
        t_global_miss();
        t_hit_and_split();
        t_first_touch();
        t_reuse();
        t_multi_match();
        t_writebacks();
        t_full_set();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule